// File: doc/BRIEF.md
# Linked descriptor reload controller

The controller keeps a small table of transfer descriptors and feeds them one at a time to an address generator. Each descriptor names its successor through a link field. When the generator reports that the running transfer has finished, the controller copies the successor into the active register set, one word per clock, and then issues the next start. The chain stops at an entry whose link holds the null value 0xFFFF. Two entries that name each other therefore form an endless ping-pong loop, and no processor has to step in.

The host fills the table through a word-wide write port with byte enables, so a single 16-bit field can be changed and the rest of the word is left alone. The host starts a chain by naming its first entry. A separate set-final command writes the null link into a chosen entry, which cuts a running chain short. Each transfer may carry a completion code. Per-code flags and a chain-done flag record progress, and the host can poll them at any time. A new start clears them all.

Descriptor layout, eight 32-bit words per entry: word 0 holds options with the completion code in bits [3:0]; word 1 the source; word 2 the destination; word 3 {B count, A count}; word 4 {B destination stride, B source stride}; word 5 {B count reload, link} with the link in bits [15:0]; word 6 {C destination stride, C source stride}; word 7 the C count in bits [15:0]. The controller decodes only the code and the link. The other fields pass through to the generator on `act_desc`, with word w at bits [32w+31:32w].

The sequencer has four states:
- IDLE: no chain is active.
- LOAD: descriptor words are being copied.
- ISSUE: a one-cycle start to the generator.
- RUN: waiting for completion.

The transitions are:
- kick: IDLE to LOAD, when a start request is sampled.
- copied: LOAD to ISSUE, after the last word.
- launch: ISSUE to RUN, always.
- relink: RUN to LOAD, on completion with a non-null link.
- finish: RUN to IDLE, on completion with a null link.

Top module: `chain_reload_ctrl`

## Requirements
- R1: After reset the controller is idle. `busy`, `xfer_go`, `chain_done`, `code_flags` and `act_desc` are all zero, and both host ports are ready. Every table entry resets to zero except the link (word 5, bits [15:0]), which resets to 0xFFFF.
- R2: A host write that is accepted updates only those bytes of the addressed word of the addressed entry whose `wr_be` bit is set.
- R3: A start request is accepted only in IDLE. Acceptance sets `busy` and clears `chain_done` and every code flag on the next cycle. A start request while busy has no effect on the active set or the chain.
- R4: The copy takes exactly eight cycles in LOAD, one word per cycle. `xfer_go` is high for exactly one cycle, eight edges after the edge that accepted the start (or the completion that relinked).
- R5: While `xfer_go` is raised and throughout RUN, `act_desc` equals the contents of the entry at copy time and does not change.
- R6: On `xfer_done` in RUN with a link other than 0xFFFF, the entry selected by the low index bits of the link is loaded and a new start is issued. The chain runs exactly as many transfers as it has entries.
- R7: On `xfer_done` in RUN with link 0xFFFF, no reload happens. On the next cycle `busy` is low and `chain_done` is high.
- R8: Two entries that link to each other alternate without end, and `chain_done` stays low.
- R9: When a transfer with a nonzero code k (word 0, bits [3:0]) completes, `code_flags[k]` is set and stays set until the next accepted start. `code_flags[0]` mirrors `chain_done`.
- R10: An accepted set-final command writes 0xFFFF into the link of the named entry and leaves its other fields unchanged, so a running chain ends after that entry.
- R11: During LOAD, a write or set-final aimed at the entry being copied is stalled (`wr_ready` / `fin_ready` low) until the copy ends, and the copy sees the old contents. Other entries are never stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host word write request |
| wr_entry | input | IDX_W | Entry index of the write |
| wr_word | input | 3 | Word index within the entry |
| wr_data | input | 32 | Write data |
| wr_be | input | 4 | Byte enables of the write |
| wr_ready | output | 1 | Write can be accepted this cycle |
| fin_en | input | 1 | Set-final request |
| fin_entry | input | IDX_W | Entry whose link becomes null |
| fin_ready | output | 1 | Set-final can be accepted this cycle |
| start_req | input | 1 | Start a chain |
| start_entry | input | IDX_W | First entry of the chain |
| busy | output | 1 | A chain is active |
| xfer_go | output | 1 | One-cycle start to the address generator |
| xfer_done | input | 1 | Completion from the address generator |
| act_desc | output | 256 | Active descriptor, eight words |
| chain_done | output | 1 | Last chain ended at a null link |
| code_flags | output | NCODES | Per-code completion flags, bit 0 = chain done |

## Verification
A wrong word counter or state shows at the ports within one descriptor time. `xfer_go` then arrives earlier or later than eight edges after the kick, or `act_desc` differs from the entry's table contents at that start. A wrong current-entry or link decode shows on the next relink: the wrong descriptor appears, or the chain ends early or runs on, which the transfer count at the end of each chain exposes. A lost or stray flag update shows in `code_flags` right after the final completion. A bad stall compare shows in the ready outputs in the first LOAD cycle, and later as new contents leaking into the copy.

// File: rtl/crl_pkg.sv
`timescale 1ns/1ps
package crl_pkg;
    localparam int WORDS     = 8;
    localparam int WORD_W    = 32;
    localparam int SEL_W     = $clog2(WORDS);
    localparam int LANES     = WORD_W / 8;
    localparam int CODE_WORD = 0;
    localparam int LINK_WORD = 5;
    localparam int LINK_W    = 16;
    localparam logic [LINK_W-1:0] LINK_NULL = 16'hFFFF;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_ISSUE,
        ST_RUN
    } crl_state_e;
endpackage

// File: rtl/crl_desc_table.sv
`timescale 1ns/1ps
module crl_desc_table import crl_pkg::*; #(
    parameter int DEPTH = 8,
    parameter int IDX_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_fire,
    input  logic [IDX_W-1:0]  wr_entry,
    input  logic [SEL_W-1:0]  wr_word,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [LANES-1:0]  wr_be,
    input  logic              fin_fire,
    input  logic [IDX_W-1:0]  fin_entry,
    input  logic [IDX_W-1:0]  rd_entry,
    input  logic [SEL_W-1:0]  rd_word,
    output logic [WORD_W-1:0] rd_data
);
    localparam int CELLS  = DEPTH * WORDS;
    localparam int ADDR_W = IDX_W + SEL_W;

    logic [WORD_W-1:0] cells [CELLS];
    logic [ADDR_W-1:0] wr_addr;
    logic [ADDR_W-1:0] fin_addr;
    logic [ADDR_W-1:0] rd_addr;
    logic [WORD_W-1:0] old_word;
    logic [WORD_W-1:0] merged;

    assign wr_addr  = {wr_entry, wr_word};
    assign fin_addr = {fin_entry, SEL_W'(LINK_WORD)};
    assign rd_addr  = {rd_entry, rd_word};
    assign old_word = cells[wr_addr];
    assign rd_data  = cells[rd_addr];

    // byte-lane merge: only enabled lanes take new data
    for (genvar b = 0; b < LANES; b++) begin : g_lane
        assign merged[b*8 +: 8] = wr_be[b] ? wr_data[b*8 +: 8] : old_word[b*8 +: 8];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < CELLS; i++) begin
                cells[i] <= ((i % WORDS) == LINK_WORD) ? WORD_W'(LINK_NULL) : '0;
            end
        end else begin
            if (wr_fire) begin
                cells[wr_addr] <= merged;
            end
            if (fin_fire) begin
                cells[fin_addr][LINK_W-1:0] <= LINK_NULL;
            end
        end
    end
endmodule

// File: rtl/crl_active_set.sv
`timescale 1ns/1ps
module crl_active_set import crl_pkg::*; #(
    parameter int CODE_W = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load_en,
    input  logic [SEL_W-1:0]        load_word,
    input  logic [WORD_W-1:0]       load_data,
    output logic [WORDS*WORD_W-1:0] act_flat,
    output logic [LINK_W-1:0]       link,
    output logic [CODE_W-1:0]       code
);
    logic [WORD_W-1:0] slot [WORDS];

    for (genvar w = 0; w < WORDS; w++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot[w] <= '0;
            end else if (load_en && (load_word == SEL_W'(w))) begin
                slot[w] <= load_data;
            end
        end
        assign act_flat[w*WORD_W +: WORD_W] = slot[w];
    end

    assign link = slot[LINK_WORD][LINK_W-1:0];
    assign code = slot[CODE_WORD][CODE_W-1:0];
endmodule

// File: rtl/crl_seq_fsm.sv
`timescale 1ns/1ps
module crl_seq_fsm import crl_pkg::*; #(
    parameter int IDX_W  = 3,
    parameter int NCODES = 16,
    parameter int CODE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_req,
    input  logic [IDX_W-1:0]  start_entry,
    input  logic              xfer_done,
    input  logic [LINK_W-1:0] link,
    input  logic [CODE_W-1:0] code,
    output crl_state_e        state,
    output logic [IDX_W-1:0]  cur_entry,
    output logic [SEL_W-1:0]  word_sel,
    output logic              load_en,
    output logic              xfer_go,
    output logic              busy,
    output logic              chain_done,
    output logic [NCODES-1:0] code_flags
);
    localparam logic [SEL_W-1:0] LAST_WORD = SEL_W'(WORDS - 1);

    crl_state_e         st_q, st_d;
    logic [IDX_W-1:0]   cur_q;
    logic [SEL_W-1:0]   cnt_q;
    logic [NCODES-1:1]  flags_q;
    logic               done_q;
    logic               last_word;
    logic               chain_end;

    assign last_word = (cnt_q == LAST_WORD);
    assign chain_end = (link == LINK_NULL);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // transitions: kick, copied, launch, relink, finish
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (start_req) st_d = ST_LOAD;
            ST_LOAD:  if (last_word) st_d = ST_ISSUE;
            ST_ISSUE: st_d = ST_RUN;
            ST_RUN:   if (xfer_done) st_d = chain_end ? ST_IDLE : ST_LOAD;
        endcase
    end

    // outputs
    always_comb begin
        load_en    = (st_q == ST_LOAD);
        xfer_go    = (st_q == ST_ISSUE);
        busy       = (st_q != ST_IDLE);
        state      = st_q;
        cur_entry  = cur_q;
        word_sel   = cnt_q;
        chain_done = done_q;
        code_flags = {flags_q, done_q};
    end

    // entry pointer, word counter and completion flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q   <= '0;
            cnt_q   <= '0;
            flags_q <= '0;
            done_q  <= 1'b0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (start_req) begin
                        cur_q   <= start_entry;
                        cnt_q   <= '0;
                        flags_q <= '0;
                        done_q  <= 1'b0;
                    end
                end
                ST_LOAD: cnt_q <= cnt_q + 1'b1;
                ST_ISSUE: ;
                ST_RUN: begin
                    if (xfer_done) begin
                        if (code != '0) flags_q[code] <= 1'b1;
                        if (chain_end) begin
                            done_q <= 1'b1;
                        end else begin
                            cur_q <= link[IDX_W-1:0];
                            cnt_q <= '0;
                        end
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/chain_reload_ctrl.sv
`timescale 1ns/1ps
module chain_reload_ctrl import crl_pkg::*; #(
    parameter int DEPTH  = 8,
    parameter int NCODES = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [IDX_W-1:0]        wr_entry,
    input  logic [SEL_W-1:0]        wr_word,
    input  logic [WORD_W-1:0]       wr_data,
    input  logic [LANES-1:0]        wr_be,
    output logic                    wr_ready,
    input  logic                    fin_en,
    input  logic [IDX_W-1:0]        fin_entry,
    output logic                    fin_ready,
    input  logic                    start_req,
    input  logic [IDX_W-1:0]        start_entry,
    output logic                    busy,
    output logic                    xfer_go,
    input  logic                    xfer_done,
    output logic [WORDS*WORD_W-1:0] act_desc,
    output logic                    chain_done,
    output logic [NCODES-1:0]       code_flags
);
    localparam int CODE_W = $clog2(NCODES);

    crl_state_e         st_q;
    logic [IDX_W-1:0]   cur_entry;
    logic [SEL_W-1:0]   word_sel;
    logic               load_en;
    logic [WORD_W-1:0]  rd_data;
    logic [LINK_W-1:0]  link;
    logic [CODE_W-1:0]  code;
    logic               copying;

    assign copying   = (st_q == ST_LOAD);
    assign wr_ready  = !(copying && (wr_entry  == cur_entry));
    assign fin_ready = !(copying && (fin_entry == cur_entry));

    crl_desc_table #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_fire   (wr_en && wr_ready),
        .wr_entry  (wr_entry),
        .wr_word   (wr_word),
        .wr_data   (wr_data),
        .wr_be     (wr_be),
        .fin_fire  (fin_en && fin_ready),
        .fin_entry (fin_entry),
        .rd_entry  (cur_entry),
        .rd_word   (word_sel),
        .rd_data   (rd_data)
    );

    crl_active_set #(.CODE_W(CODE_W)) u_active (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (load_en),
        .load_word (word_sel),
        .load_data (rd_data),
        .act_flat  (act_desc),
        .link      (link),
        .code      (code)
    );

    crl_seq_fsm #(.IDX_W(IDX_W), .NCODES(NCODES), .CODE_W(CODE_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_req   (start_req),
        .start_entry (start_entry),
        .xfer_done   (xfer_done),
        .link        (link),
        .code        (code),
        .state       (st_q),
        .cur_entry   (cur_entry),
        .word_sel    (word_sel),
        .load_en     (load_en),
        .xfer_go     (xfer_go),
        .busy        (busy),
        .chain_done  (chain_done),
        .code_flags  (code_flags)
    );
endmodule

// File: rtl/crl_checker.sv
`timescale 1ns/1ps
module crl_checker import crl_pkg::*; #(
    parameter int NCODES = 16
) (
    input logic                    clk,
    input logic                    rst_n,
    input crl_state_e              st,
    input logic                    start_req,
    input logic                    busy,
    input logic                    xfer_go,
    input logic                    wr_ready,
    input logic                    fin_ready,
    input logic                    chain_done,
    input logic [NCODES-1:0]       code_flags,
    input logic [WORDS*WORD_W-1:0] act_desc
);
    logic [7:0] load_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                load_run <= '0;
        else if (st == ST_LOAD)    load_run <= load_run + 8'd1;
        else if (st != ST_ISSUE)   load_run <= '0;
    end

    p_start_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && start_req) |=> (busy && code_flags == '0));

    p_copy_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ISSUE) |-> (load_run == 8'(WORDS)));

    p_go_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_go |=> !xfer_go);

    p_go_after_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_go |-> ($past(st) == ST_LOAD));

    p_active_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN) |=> $stable(act_desc));

    p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        chain_done |-> !busy);

    p_flags_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(st == ST_IDLE && start_req) |=>
            ((code_flags[NCODES-1:1] & $past(code_flags[NCODES-1:1])) == $past(code_flags[NCODES-1:1])));

    p_stall_only_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_ready || !fin_ready) |-> (st == ST_LOAD));
endmodule

bind chain_reload_ctrl crl_checker #(.NCODES(NCODES)) i_crl_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .st         (st_q),
    .start_req  (start_req),
    .busy       (busy),
    .xfer_go    (xfer_go),
    .wr_ready   (wr_ready),
    .fin_ready  (fin_ready),
    .chain_done (chain_done),
    .code_flags (code_flags),
    .act_desc   (act_desc)
);

// File: tb/test_chain_reload_ctrl.sv
`timescale 1ns/1ps
module test_chain_reload_ctrl;
    import crl_pkg::*;

    localparam int DEPTH  = 8;
    localparam int NCODES = 16;
    localparam int IDX_W  = 3;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               wr_en = 1'b0;
    logic [IDX_W-1:0]   wr_entry = '0;
    logic [2:0]         wr_word = '0;
    logic [31:0]        wr_data = '0;
    logic [3:0]         wr_be = '0;
    logic               wr_ready;
    logic               fin_en = 1'b0;
    logic [IDX_W-1:0]   fin_entry = '0;
    logic               fin_ready;
    logic               start_req = 1'b0;
    logic [IDX_W-1:0]   start_entry = '0;
    logic               busy;
    logic               xfer_go;
    logic               xfer_done = 1'b0;
    logic [255:0]       act_desc;
    logic               chain_done;
    logic [NCODES-1:0]  code_flags;

    logic [31:0] mdl [DEPTH][WORDS];
    int n_cmp = 0;
    int n_bad = 0;

    chain_reload_ctrl #(.DEPTH(DEPTH), .NCODES(NCODES)) i_chain_reload_ctrl (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_entry(wr_entry), .wr_word(wr_word), .wr_data(wr_data),
        .wr_be(wr_be), .wr_ready(wr_ready),
        .fin_en(fin_en), .fin_entry(fin_entry), .fin_ready(fin_ready),
        .start_req(start_req), .start_entry(start_entry), .busy(busy),
        .xfer_go(xfer_go), .xfer_done(xfer_done), .act_desc(act_desc),
        .chain_done(chain_done), .code_flags(code_flags)
    );

    always #5 clk = ~clk;

    function automatic logic [255:0] pack_entry(input int e);
        logic [255:0] r;
        for (int w = 0; w < WORDS; w++) r[w*32 +: 32] = mdl[e][w];
        return r;
    endfunction

    task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic hw(input int e, input int w, input logic [31:0] d, input logic [3:0] be);
        wr_en = 1'b1; wr_entry = IDX_W'(e); wr_word = 3'(w); wr_data = d; wr_be = be;
        #1;
        while (!wr_ready) begin @(negedge clk); #1; end
        @(posedge clk);
        for (int b = 0; b < 4; b++) if (be[b]) mdl[e][w][b*8 +: 8] = d[b*8 +: 8];
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_final(input int e);
        fin_en = 1'b1; fin_entry = IDX_W'(e);
        #1;
        while (!fin_ready) begin @(negedge clk); #1; end
        @(posedge clk);
        mdl[e][LINK_WORD][15:0] = 16'hFFFF;
        @(negedge clk);
        fin_en = 1'b0;
    endtask

    task automatic pulse_done();
        xfer_done = 1'b1;
        @(posedge clk);
        @(negedge clk);
        xfer_done = 1'b0;
    endtask

    task automatic run_chain(input int first, input int final_at, input bit poke, output int nx);
        logic [NCODES-1:1] expf;
        logic [3:0]        code;
        logic [15:0]       link;
        int                cur;
        int                n;
        expf = '0;
        cur  = first;
        nx   = 0;
        start_req = 1'b1; start_entry = IDX_W'(first);
        @(posedge clk); @(negedge clk);
        start_req = 1'b0;
        chk("R3 start accepted, flags cleared", {busy, chain_done, code_flags}, {1'b1, 1'b0, 16'h0});
        for (int k = 0; k < 64; k++) begin
            n = 1;
            while (!xfer_go && n < 40) begin @(negedge clk); n++; end
            chk("R4 copy latency", n, 9);
            chk("R6 loaded entry", act_desc, pack_entry(cur));
            chk("R8 no done while chaining", chain_done, 0);
            @(negedge clk);
            chk("R4 go single cycle", xfer_go, 0);
            if (poke && k == 0) begin
                start_req = 1'b1; start_entry = IDX_W'(cur + 1);
                @(negedge clk);
                start_req = 1'b0;
                chk("R3 start ignored busy", busy, 1);
                chk("R3 start ignored active", act_desc, pack_entry(cur));
            end
            repeat ($urandom_range(0, 3)) @(negedge clk);
            chk("R5 active hold", act_desc, pack_entry(cur));
            if (k == final_at) set_final(int'(mdl[cur][LINK_WORD][IDX_W-1:0]));
            code = mdl[cur][CODE_WORD][3:0];
            if (code != 4'd0) expf[code] = 1'b1;
            link = mdl[cur][LINK_WORD][15:0];
            pulse_done();
            nx++;
            if (link == 16'hFFFF) begin
                chk("R7 end of chain", {busy, chain_done}, {1'b0, 1'b1});
                chk("R9 code flags", code_flags, {expf, 1'b1});
                return;
            end
            chk("R6 relink keeps busy", busy, 1);
            cur = int'(link[IDX_W-1:0]);
        end
    endtask

    initial begin
        #1_500_000;
        n_cmp++; n_bad++;
        $display("FAIL R4 watchdog: actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int           nx;
        int           n;
        int           ord [DEPTH];
        int           len;
        int           tmp;
        int           j;
        int unsigned  seed;
        logic [255:0] old;
        seed = $urandom(32'd20240611);
        for (int e = 0; e < DEPTH; e++)
            for (int w = 0; w < WORDS; w++)
                mdl[e][w] = (w == LINK_WORD) ? 32'h0000_FFFF : 32'h0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 reset outputs", {busy, xfer_go, chain_done, code_flags}, '0);
        chk("R1 reset active set", act_desc, '0);
        chk("R1 reset ready", {wr_ready, fin_ready}, 2'b11);
        run_chain(7, -1, 1'b0, nx);
        chk("R1 reset link null", nx, 1);

        // R2 partial writes
        hw(2, 0, 32'h0000_0106, 4'hF);
        hw(2, 3, 32'h1122_3344, 4'hF);
        hw(2, 3, 32'hAABB_CCDD, 4'b0101);
        hw(2, 5, 32'h7777_0003, 4'b1100);
        hw(2, 7, 32'hDEAD_0010, 4'b0011);
        run_chain(2, -1, 1'b0, nx);
        chk("R2 byte-enable single transfer", nx, 1);

        // R11 stall on the entry under copy
        start_req = 1'b1; start_entry = 3'd2;
        @(posedge clk); @(negedge clk);
        start_req = 1'b0;
        wr_entry = 3'd3; fin_entry = 3'd3;
        #1;
        chk("R11 other entry not stalled", {wr_ready, fin_ready}, 2'b11);
        old = pack_entry(2);
        wr_en = 1'b1; wr_entry = 3'd2; wr_word = 3'd1; wr_data = 32'hA5A5_0001; wr_be = 4'hF;
        fin_entry = 3'd2;
        #1;
        chk("R11 stalled", {wr_ready, fin_ready}, 2'b00);
        n = 0;
        while (!wr_ready && n < 40) begin @(negedge clk); #1; n++; end
        chk("R11 stall length", n, 8);
        chk("R11 stall ends with copy", xfer_go, 1);
        chk("R11 copy saw old contents", act_desc, old);
        @(posedge clk);
        mdl[2][1] = 32'hA5A5_0001;
        @(negedge clk);
        wr_en = 1'b0;
        pulse_done();
        chk("R7 single entry done", {busy, chain_done}, {1'b0, 1'b1});
        run_chain(2, -1, 1'b0, nx);
        chk("R11 write landed after copy", nx, 1);

        // R8 ping-pong loop, R10 set final, R3 start while busy
        for (int w = 0; w < WORDS; w++) begin
            hw(0, w, $urandom, 4'hF);
            hw(1, w, $urandom, 4'hF);
        end
        hw(0, 0, 32'h0000_0003, 4'b0001);
        hw(1, 0, 32'h0000_0005, 4'b0001);
        hw(0, 5, 32'h0000_0001, 4'b0011);
        hw(1, 5, 32'h0000_0000, 4'b0011);
        run_chain(0, 5, 1'b1, nx);
        chk("R8 R10 ping-pong cut by set final", nx, 7);

        // random chains
        for (int it = 0; it < 8; it++) begin
            for (int e = 0; e < DEPTH; e++)
                for (int w = 0; w < WORDS; w++)
                    hw(e, w, $urandom, 4'hF);
            for (int p = 0; p < 4; p++)
                hw($urandom_range(0, DEPTH-1), $urandom_range(0, WORDS-1), $urandom,
                   4'($urandom_range(1, 15)));
            for (int i = 0; i < DEPTH; i++) ord[i] = i;
            for (int i = DEPTH-1; i > 0; i--) begin
                j = $urandom_range(0, i);
                tmp = ord[i]; ord[i] = ord[j]; ord[j] = tmp;
            end
            len = $urandom_range(1, DEPTH);
            for (int i = 0; i < len; i++)
                hw(ord[i], LINK_WORD,
                   (i == len-1) ? 32'h0000_FFFF : {16'h0, 16'(ord[i+1])}, 4'b0011);
            run_chain(ord[0], -1, it == 3, nx);
            chk("R6 chain length", nx, len);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule